// File: doc/BRIEF.md
# Sensor Interrupt Pin Router

This block takes the two internal event strobes of a sensor core and turns them into the level on one physical interrupt pin. The first strobe is data-ready, raised once per output sample. The second is sample-buffer-full. Each event can be routed to the pin on its own. The pin can be switched off, given either polarity, and set to drive in one of two ways. In latched mode the pin holds while a routed event is pending. In pulse mode each routed event gives one pulse of fixed width.

A small byte-wide register bus configures the block and reads it back. A status byte records every accepted event whether it is routed or not, and reading that byte clears it. Routing and pin configuration are frozen while the core's operating bit is set. This makes the host configure the pin in standby before it starts sampling. Data-ready is accepted only when its enable bit in the main control byte is set.

Top module: `irq_pin_router`

## Requirements
- R1: After reset the main control byte (0x1A), the routing byte (0x23) and the status byte (0x17) read 0x00. The pin control byte (0x20) reads 0x10. irq_o is low.
- R2: Writes to 0x1A, 0x20 and 0x23 are read back unchanged. In 0x1A, bit 7 is the operating bit and bit 5 enables data-ready. In 0x20, bit 5 enables the pin, bit 4 selects active-high, and bit 3 selects pulse mode, so 0x38 gives an enabled, active-high, pulsed pin. In 0x23, bit 4 routes data-ready and bit 6 routes buffer-full.
- R3: While bit 7 of 0x1A is set, writes to 0x20 and 0x23 are ignored. Writes to 0x1A are always accepted.
- R4: A data-ready strobe seen while bit 5 of 0x1A is clear has no effect on the status byte or on the pin.
- R5: In the status byte, bit 4 records data-ready and bit 6 records buffer-full, regardless of routing. A read of 0x17 returns the value before the read and then clears the byte. An event in the same cycle as that read stays recorded.
- R6: While bit 5 of 0x20 is clear, irq_o stays at its inactive level, whatever events occur.
- R7: With bit 4 of 0x20 set, the pin is asserted high and idles low. With bit 4 clear, both levels are inverted.
- R8: In pulse mode, a routed event asserts the pin from the next cycle for exactly PULSE_CYCLES cycles. The default is 10000, which is 40 us at 250 MHz and lies inside the 30 to 50 us window.
- R9: A routed event that arrives during a pulse restarts the full pulse width from the next cycle.
- R10: In latched mode, the pin is asserted from the cycle after a routed event for as long as a routed status bit stays set. It is released in the cycle after the status read that clears that bit.
- R11: An event whose routing bit is clear does not change the pin in either mode.
- R12: Read data is presented on rdata_o one cycle after rd_en_i. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drdy_i | input | 1 | Data-ready strobe, one cycle per sample |
| buf_full_i | input | 1 | Sample-buffer-full strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt pin level |

## Verification
The directed phases use isolated single events, to separate pulse width from latched hold and active-high from active-low levels. Back-to-back buffer-full events inside one pulse show whether the width restarts or simply runs out. A strobe that meets a status read in the same cycle shows whether the set or the clear wins. Events arriving with the routing bit cleared, the data-ready enable off, or the pin disabled show that each gate acts on its own. A long random mix of strobes, status reads and configuration writes, including writes made while the operating bit is set, compares the pin and every read against a bench model of the requirements.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned N_EVT = 2;

  localparam logic [REG_W-1:0] ADDR_STAT  = 8'h17;
  localparam logic [REG_W-1:0] ADDR_MAIN  = 8'h1A;
  localparam logic [REG_W-1:0] ADDR_PIN   = 8'h20;
  localparam logic [REG_W-1:0] ADDR_ROUTE = 8'h23;

  localparam int unsigned MAIN_RUN_BIT  = 7;
  localparam int unsigned MAIN_DRDY_BIT = 5;
  localparam int unsigned PIN_EN_BIT    = 5;
  localparam int unsigned PIN_POL_BIT   = 4;
  localparam int unsigned PIN_PULSE_BIT = 3;

  localparam logic [REG_W-1:0] PIN_RST = 8'h10;

  typedef enum int unsigned {
    EV_DRDY = 0,
    EV_BUFF = 1
  } evt_e;

  // bit position of each event in the routing and status bytes
  localparam int unsigned EVT_BIT [N_EVT] = '{4, 6};

  typedef struct packed {
    logic             run;
    logic             drdy_en;
    logic             pin_en;
    logic             pol_high;
    logic             pulse_mode;
    logic [N_EVT-1:0] route;
  } cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] main_o,
  output logic [REG_W-1:0] pin_o,
  output logic [REG_W-1:0] route_o,
  output cfg_t             cfg_o
);
  logic [REG_W-1:0] main_q, pin_q, route_q;
  logic             locked;

  assign locked = main_q[MAIN_RUN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q  <= '0;
      pin_q   <= PIN_RST;
      route_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_MAIN:  main_q <= wdata_i;
        ADDR_PIN:   if (!locked) pin_q <= wdata_i;
        ADDR_ROUTE: if (!locked) route_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign main_o  = main_q;
  assign pin_o   = pin_q;
  assign route_o = route_q;

  assign cfg_o.run        = main_q[MAIN_RUN_BIT];
  assign cfg_o.drdy_en    = main_q[MAIN_DRDY_BIT];
  assign cfg_o.pin_en     = pin_q[PIN_EN_BIT];
  assign cfg_o.pol_high   = pin_q[PIN_POL_BIT];
  assign cfg_o.pulse_mode = pin_q[PIN_PULSE_BIT];

  for (genvar g = 0; g < N_EVT; g++) begin : g_route
    assign cfg_o.route[g] = route_q[EVT_BIT[g]];
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic sts_q;
    // a set in the clearing cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q <= 1'b0;
      else if (set_i[g]) sts_q <= 1'b1;
      else if (clr_i)    sts_q <= 1'b0;
    end
    assign sts_o[g] = sts_q;
  end
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage #(
  parameter int unsigned PULSE_CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic hold_i,
  input  logic en_i,
  input  logic pol_high_i,
  input  logic pulse_mode_i,
  output logic pin_o
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          active;

  // retrigger reloads the full width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (trig_i)       cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = pulse_mode_i ? (cnt_q != '0) : hold_i;
  assign pin_o  = (en_i && active) ? pol_high_i : !pol_high_i;
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_router_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drdy_i,
  input  logic             buf_full_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  cfg_t             cfg;
  logic [REG_W-1:0] main_b, pin_b, route_b, sts_b;
  logic [N_EVT-1:0] evt, sts;
  logic             sts_clr, routed_evt, routed_hold;
  logic [REG_W-1:0] rdata_q, rd_mux;

  irq_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .main_o  (main_b),
    .pin_o   (pin_b),
    .route_o (route_b),
    .cfg_o   (cfg)
  );

  assign evt[EV_DRDY] = drdy_i && cfg.drdy_en;
  assign evt[EV_BUFF] = buf_full_i;
  assign sts_clr      = rd_en_i && (addr_i == ADDR_STAT);

  irq_status #(.N(N_EVT)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (sts_clr),
    .sts_o  (sts)
  );

  assign routed_evt  = |(evt & cfg.route);
  assign routed_hold = |(sts & cfg.route);

  irq_pin_stage #(.PULSE_CYCLES(PULSE_CYCLES)) u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (routed_evt),
    .hold_i       (routed_hold),
    .en_i         (cfg.pin_en),
    .pol_high_i   (cfg.pol_high),
    .pulse_mode_i (cfg.pulse_mode),
    .pin_o        (irq_o)
  );

  always_comb begin
    sts_b = '0;
    for (int i = 0; i < N_EVT; i++) sts_b[EVT_BIT[i]] = sts[i];
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT:  rd_mux = sts_b;
      ADDR_MAIN:  rd_mux = main_b;
      ADDR_PIN:   rd_mux = pin_b;
      ADDR_ROUTE: rd_mux = route_b;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk
  import irq_router_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             drdy_i,
  input logic             wr_en_i,
  input logic             irq_o,
  input cfg_t             cfg_i,
  input logic [N_EVT-1:0] sts_i,
  input logic             clr_i,
  input logic             routed_i,
  input logic [REG_W-1:0] pin_b_i,
  input logic [REG_W-1:0] route_b_i
);
  a_r6_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.pin_en |-> irq_o == !cfg_i.pol_high);

  a_r4_drdy_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_i[EV_DRDY] && drdy_i && !cfg_i.drdy_en) |=> !sts_i[EV_DRDY]);

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[EV_BUFF] && !clr_i) |=> sts_i[EV_BUFF]);

  a_r3_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.run |=> ($stable(pin_b_i) && $stable(route_b_i)));

  a_r8_pulse_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (routed_i && cfg_i.pin_en && cfg_i.pulse_mode && !wr_en_i) |=> irq_o == cfg_i.pol_high);
endmodule

bind irq_pin_router irq_pin_router_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .drdy_i    (drdy_i),
  .wr_en_i   (wr_en_i),
  .irq_o     (irq_o),
  .cfg_i     (cfg),
  .sts_i     (sts),
  .clr_i     (sts_clr),
  .routed_i  (routed_evt),
  .pin_b_i   (pin_b),
  .route_b_i (route_b)
);

// File: tb/sim_irq_pin_router.sv
`timescale 1ns/1ps
module sim_irq_pin_router;
  localparam int P = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       drdy = 1'b0, buff = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  always #2 clk = ~clk;

  irq_pin_router #(.PULSE_CYCLES(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .drdy_i(drdy), .buf_full_i(buff),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  // requirement model
  logic [7:0] m_main, m_pin, m_route, m_rdata;
  logic [1:0] m_sts;
  int         m_cnt;
  bit         m_rdv;

  function automatic logic [7:0] sts_byte(logic [1:0] s);
    return {1'b0, s[1], 1'b0, s[0], 4'b0};
  endfunction

  function automatic logic [7:0] rd_val(logic [7:0] a);
    case (a)
      8'h17: return sts_byte(m_sts);
      8'h1A: return m_main;
      8'h20: return m_pin;
      8'h23: return m_route;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_pin();
    logic act, pol;
    pol = m_pin[4];
    if (!m_pin[5]) return !pol;
    if (m_pin[3]) act = (m_cnt != 0);
    else act = |({m_sts[1] & m_route[6], m_sts[0] & m_route[4]});
    return act ? pol : !pol;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_main = 8'h00; m_pin = 8'h10; m_route = 8'h00;
      m_sts = 2'b00; m_cnt = 0; m_rdv = 0; m_rdata = 8'h00;
    end else begin
      logic ed, eb, rt;
      logic [1:0] ns;
      ed = drdy && m_main[5];
      eb = buff;
      rt = (ed && m_route[4]) || (eb && m_route[6]);
      m_rdv = rd;
      if (rd) m_rdata = rd_val(addr);
      ns = m_sts;
      if (rd && addr == 8'h17) ns = 2'b00;
      ns = ns | {eb, ed};
      if (rt) m_cnt = P;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr) begin
        if (addr == 8'h20 && !m_main[7]) m_pin = wdata;
        if (addr == 8'h23 && !m_main[7]) m_route = wdata;
        if (addr == 8'h1A) m_main = wdata;
      end
      m_sts = ns;
    end
  end

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("irq_o", {7'b0, irq}, {7'b0, exp_pin()});
      if (m_rdv) check("rdata_o", rdata, m_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    wr = 1; addr = a; wdata = d; @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [7:0] a);
    rd = 1; addr = a; @(negedge clk); rd = 0;
  endtask

  task automatic ev(logic d, logic b);
    drdy = d; buff = b; @(negedge clk); drdy = 0; buff = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    idle(3);
    rst_n = 1;
    tag = "R1";
    idle(2);
    check("reset irq_o", {7'b0, irq}, 8'h00);
    rd_reg(8'h1A); rd_reg(8'h20); rd_reg(8'h23); rd_reg(8'h17); idle(1);

    tag = "R2";
    wr_reg(8'h20, 8'h38); wr_reg(8'h23, 8'h50); wr_reg(8'h1A, 8'h20);
    rd_reg(8'h20); rd_reg(8'h23); rd_reg(8'h1A); idle(1);

    tag = "R3";
    wr_reg(8'h1A, 8'hA0); wr_reg(8'h20, 8'h00); wr_reg(8'h23, 8'h00);
    rd_reg(8'h20); rd_reg(8'h23); rd_reg(8'h1A);
    wr_reg(8'h1A, 8'h20); wr_reg(8'h23, 8'h50); rd_reg(8'h23); idle(1);

    tag = "R8";
    ev(1, 0); idle(P + 4);

    tag = "R9";
    ev(0, 1); idle(4); ev(0, 1); idle(2); ev(1, 0); idle(P + 4);

    tag = "R5";
    rd_reg(8'h17); rd_reg(8'h17);
    drdy = 1; rd = 1; addr = 8'h17; @(negedge clk); drdy = 0; rd = 0;
    rd_reg(8'h17); idle(P + 2);

    tag = "R4";
    wr_reg(8'h1A, 8'h00); ev(1, 0); idle(P + 2); rd_reg(8'h17); idle(1);

    tag = "R10";
    wr_reg(8'h20, 8'h30); wr_reg(8'h1A, 8'h20);
    ev(0, 1); idle(P + 5); rd_reg(8'h17); idle(3);

    tag = "R11";
    wr_reg(8'h23, 8'h10); ev(0, 1); idle(4); rd_reg(8'h17);
    wr_reg(8'h20, 8'h38); ev(0, 1); idle(P + 2); rd_reg(8'h17); idle(1);

    tag = "R7";
    wr_reg(8'h20, 8'h28); idle(2); ev(1, 0); idle(P + 3);
    wr_reg(8'h20, 8'h20); ev(1, 0); idle(4); rd_reg(8'h17); idle(2);

    tag = "R6";
    wr_reg(8'h23, 8'h50);
    wr_reg(8'h20, 8'h08); ev(1, 1); idle(P + 2);
    wr_reg(8'h20, 8'h18); ev(1, 1); idle(P + 2); rd_reg(8'h17);

    tag = "R12";
    rd_reg(8'h55); rd_reg(8'h00); idle(1);

    tag = "R5 R8 R9 R10 random";
    for (int i = 0; i < 15000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      drdy = ($urandom_range(0, 7) == 0);
      buff = ($urandom_range(0, 15) == 0);
      wr = 0; rd = 0;
      if (r < 8) begin
        rd = 1; addr = 8'h17;
      end else if (r < 11) begin
        wr = 1;
        case ($urandom_range(0, 2))
          0: begin addr = 8'h1A; wdata = 8'($urandom_range(0, 255)) & 8'hA0; end
          1: begin addr = 8'h20; wdata = 8'($urandom_range(0, 255)) & 8'h38; end
          default: begin addr = 8'h23; wdata = 8'($urandom_range(0, 255)) & 8'h50; end
        endcase
      end else if (r < 13) begin
        rd = 1; addr = 8'($urandom_range(0, 255));
      end
      @(negedge clk);
    end
    drdy = 0; buff = 0; wr = 0; rd = 0;
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule